// File: doc/BRIEF.md
# Width-Selectable Accumulator and Index Register Bank

This block holds the four general working registers of a small processor core: two accumulators and two index registers, each 16 bits wide. A single write port updates one register per clock, and a single read port returns one register. Two width flags, normally driven from the processor status word, set how the registers behave. One flag governs both accumulators and the other governs both index registers. When a group is in byte mode, writes touch only the low byte and reads return that byte zero-extended.

The bank also forms the 24-bit addresses that the surrounding core needs from the index registers. The first is an indexed effective address: an instruction operand plus the first index register, computed modulo 2^24. The second is a pair of block-move pointers, each built from a bank byte taken from the instruction and one index register. The third is a pair of 16-bit operand pointers for a repeated multiply-accumulate sequence. Instruction decode, arithmetic, memory access and the status word itself sit outside the block.

Top module: `cpu_regbank`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four registers become 0x0000. After reset, `rd_full` reads 0x0000 for every `rd_sel`.
- R2: Registers are selected by `wr_sel` and `rd_sel` with the code 0 = accumulator A, 1 = accumulator B, 2 = index X, 3 = index Y. A write with `wr_en` high updates only the selected register at the rising edge, and the other three keep their values.
- R3: When the governing width flag is 0 (word mode), a write replaces all 16 bits of the selected register with `wr_data`.
- R4: When the governing width flag is 1 (byte mode), a write replaces bits [7:0] with `wr_data[7:0]`, and bits [15:8] keep their previous value.
- R5: `acc_byte` is the width flag for codes 0 and 1 only, and `idx_byte` is the width flag for codes 2 and 3 only. Each flag has no effect on the other group's writes or reads.
- R6: `rd_data` equals `{8'h00, reg[7:0]}` when the selected register's width flag is 1, and the full register otherwise. `rd_full` always shows all 16 bits of the selected register.
- R7: `idx_addr` equals (`opnd_addr` + X) mod 2^24 in word mode. When `idx_byte` is 1, only X[7:0], zero-extended, is added.
- R8: `mv_src_addr` equals `{src_bank, X}` and `mv_dst_addr` equals `{dst_bank, Y}`. Both use all 16 bits of the index register whatever the value of `idx_byte`.
- R9: `mac_mcand_ptr` equals X and `mac_mplier_ptr` equals Y.
- R10: With `wr_en` low, no register changes at the clock edge, whatever `wr_sel`, `wr_data` and the width flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register code for the write |
| wr_data | input | 16 | Write data |
| acc_byte | input | 1 | Accumulator width flag (1 = 8-bit) |
| idx_byte | input | 1 | Index width flag (1 = 8-bit) |
| rd_sel | input | 2 | Register code for the read |
| rd_data | output | 16 | Width-adjusted read data |
| rd_full | output | 16 | Full 16-bit contents of the read register |
| opnd_addr | input | 24 | Instruction operand for indexed addressing |
| dst_bank | input | 8 | Bank byte for the block-move destination |
| src_bank | input | 8 | Bank byte for the block-move source |
| idx_addr | output | 24 | Indexed effective address |
| mv_src_addr | output | 24 | Block-move source pointer |
| mv_dst_addr | output | 24 | Block-move destination pointer |
| mac_mcand_ptr | output | 16 | Multiplicand pointer, low 16 bits |
| mac_mplier_ptr | output | 16 | Multiplier pointer, low 16 bits |

## Verification
The assertions assume that `wr_sel`, `wr_en` and both width flags are known, stable values at each rising edge. The write checks compare the register state one cycle after a write against these sampled inputs. The bench changes every input only on falling edges and releases `rst` before any write. It reads results half a cycle later through `rd_sel` and the address outputs. This keeps all sampled values settled and unambiguous.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 24;
    localparam int NUM_REG = 4;
    localparam int SEL_W   = $clog2(NUM_REG);
    localparam int BANK_W  = ADDR_W - WORD_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_ACC_A = 2'd0,
        SEL_ACC_B = 2'd1,
        SEL_IDX_X = 2'd2,
        SEL_IDX_Y = 2'd3
    } reg_sel_e;

    typedef logic [NUM_REG-1:0][WORD_W-1:0] reg_array_t;

    typedef struct packed {
        logic [ADDR_W-1:0] indexed;
        logic [ADDR_W-1:0] move_src;
        logic [ADDR_W-1:0] move_dst;
        logic [WORD_W-1:0] mac_mcand;
        logic [WORD_W-1:0] mac_mplier;
    } addr_bundle_t;

    // Accumulators occupy codes 0 and 1, index registers codes 2 and 3.
    function automatic logic is_acc(input logic [SEL_W-1:0] sel);
        return (sel == SEL_ACC_A) || (sel == SEL_ACC_B);
    endfunction

    function automatic logic narrow_for(input logic [SEL_W-1:0] sel,
                                        input logic acc_byte,
                                        input logic idx_byte);
        return is_acc(sel) ? acc_byte : idx_byte;
    endfunction

    // Byte mode keeps the upper byte, word mode replaces everything.
    function automatic logic [WORD_W-1:0] merge_write(input logic [WORD_W-1:0] old_v,
                                                      input logic [WORD_W-1:0] new_v,
                                                      input logic narrow);
        logic [WORD_W-1:0] res;
        res = narrow ? {old_v[WORD_W-1:BYTE_W], new_v[BYTE_W-1:0]} : new_v;
        return res;
    endfunction

    function automatic logic [WORD_W-1:0] view_width(input logic [WORD_W-1:0] v,
                                                     input logic narrow);
        logic [WORD_W-1:0] res;
        res = narrow ? {{(WORD_W-BYTE_W){1'b0}}, v[BYTE_W-1:0]} : v;
        return res;
    endfunction

endpackage

// File: rtl/regbank_store.sv
module regbank_store
    import regbank_pkg::*;
#(
    parameter int N_REGS = NUM_REG,
    parameter int DW     = WORD_W,
    localparam int SW    = $clog2(N_REGS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [SW-1:0]             wr_sel,
    input  logic [DW-1:0]             wr_data,
    input  logic                      acc_byte,
    input  logic                      idx_byte,
    output logic [N_REGS-1:0][DW-1:0] regs_q
);

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        localparam logic [SW-1:0] CODE = SW'(i);
        logic hit;
        logic narrow;

        always_comb begin
            hit    = wr_en && (wr_sel == CODE);
            narrow = narrow_for(CODE, acc_byte, idx_byte);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (hit) begin
                regs_q[i] <= merge_write(regs_q[i], wr_data, narrow);
            end
        end
    end

endmodule

// File: rtl/regbank_readport.sv
module regbank_readport
    import regbank_pkg::*;
#(
    parameter int N_REGS = NUM_REG,
    parameter int DW     = WORD_W,
    localparam int SW    = $clog2(N_REGS)
) (
    input  logic [N_REGS-1:0][DW-1:0] regs_q,
    input  logic [SW-1:0]             rd_sel,
    input  logic                      acc_byte,
    input  logic                      idx_byte,
    output logic [DW-1:0]             rd_data,
    output logic [DW-1:0]             rd_full
);

    logic narrow;

    always_comb begin
        rd_full = regs_q[rd_sel];
        narrow  = narrow_for(rd_sel, acc_byte, idx_byte);
        rd_data = view_width(rd_full, narrow);
    end

endmodule

// File: rtl/regbank_agen.sv
module regbank_agen
    import regbank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W,
    localparam int BW = AW - DW
) (
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    input  logic          idx_byte,
    input  logic [AW-1:0] opnd_addr,
    input  logic [BW-1:0] src_bank,
    input  logic [BW-1:0] dst_bank,
    output addr_bundle_t  addrs
);

    logic [DW-1:0] x_eff;
    logic [AW-1:0] x_ext;

    always_comb begin
        x_eff = view_width(idx_x, idx_byte);
        x_ext = {{BW{1'b0}}, x_eff};
        // Sum truncated to AW bits: carry out of the top bit is dropped.
        addrs.indexed    = opnd_addr + x_ext;
        addrs.move_src   = {src_bank, idx_x};
        addrs.move_dst   = {dst_bank, idx_y};
        addrs.mac_mcand  = idx_x;
        addrs.mac_mplier = idx_y;
    end

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              acc_byte,
    input  logic              idx_byte,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] rd_full,
    input  logic [ADDR_W-1:0] opnd_addr,
    input  logic [BANK_W-1:0] dst_bank,
    input  logic [BANK_W-1:0] src_bank,
    output logic [ADDR_W-1:0] idx_addr,
    output logic [ADDR_W-1:0] mv_src_addr,
    output logic [ADDR_W-1:0] mv_dst_addr,
    output logic [WORD_W-1:0] mac_mcand_ptr,
    output logic [WORD_W-1:0] mac_mplier_ptr
);

    reg_array_t   regs_w;
    addr_bundle_t addrs;

    regbank_store #(.N_REGS(NUM_REG), .DW(WORD_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .acc_byte (acc_byte),
        .idx_byte (idx_byte),
        .regs_q   (regs_w)
    );

    regbank_readport #(.N_REGS(NUM_REG), .DW(WORD_W)) u_read (
        .regs_q   (regs_w),
        .rd_sel   (rd_sel),
        .acc_byte (acc_byte),
        .idx_byte (idx_byte),
        .rd_data  (rd_data),
        .rd_full  (rd_full)
    );

    regbank_agen #(.AW(ADDR_W), .DW(WORD_W)) u_agen (
        .idx_x     (regs_w[SEL_IDX_X]),
        .idx_y     (regs_w[SEL_IDX_Y]),
        .idx_byte  (idx_byte),
        .opnd_addr (opnd_addr),
        .src_bank  (src_bank),
        .dst_bank  (dst_bank),
        .addrs     (addrs)
    );

    always_comb begin
        idx_addr       = addrs.indexed;
        mv_src_addr    = addrs.move_src;
        mv_dst_addr    = addrs.move_dst;
        mac_mcand_ptr  = addrs.mac_mcand;
        mac_mplier_ptr = addrs.mac_mplier;
    end

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
    import regbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [WORD_W-1:0] wr_data,
    input logic              acc_byte,
    input logic              idx_byte,
    input logic [SEL_W-1:0]  rd_sel,
    input logic [WORD_W-1:0] rd_data,
    input logic [WORD_W-1:0] rd_full,
    input logic [ADDR_W-1:0] mv_src_addr,
    input logic [ADDR_W-1:0] mv_dst_addr,
    input reg_array_t        regs_w
);

    logic wr_narrow;
    logic rd_narrow;
    assign wr_narrow = is_acc(wr_sel) ? acc_byte : idx_byte;
    assign rd_narrow = is_acc(rd_sel) ? acc_byte : idx_byte;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (regs_w == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_w));

    // R3
    wide_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_narrow) |=> (rd_sel != $past(wr_sel)) || (rd_full == $past(wr_data)));

    // R4
    byte_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_narrow) |=>
            (regs_w[$past(wr_sel)][WORD_W-1:BYTE_W] == $past(regs_w[wr_sel][WORD_W-1:BYTE_W])) &&
            (regs_w[$past(wr_sel)][BYTE_W-1:0] == $past(wr_data[BYTE_W-1:0])));

    // R6
    byte_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_narrow |-> (rd_data[WORD_W-1:BYTE_W] == '0) && (rd_data[BYTE_W-1:0] == rd_full[BYTE_W-1:0]));

    // R8
    move_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (mv_src_addr[WORD_W-1:0] == regs_w[SEL_IDX_X]) && (mv_dst_addr[WORD_W-1:0] == regs_w[SEL_IDX_Y]));

endmodule

bind cpu_regbank regbank_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .acc_byte    (acc_byte),
    .idx_byte    (idx_byte),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .rd_full     (rd_full),
    .mv_src_addr (mv_src_addr),
    .mv_dst_addr (mv_dst_addr),
    .regs_w      (regs_w)
);

// File: tb/sim_cpu_regbank.sv
module sim_cpu_regbank;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG_CYC   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic        acc_byte = 1'b0;
    logic        idx_byte = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic [15:0] rd_full;
    logic [23:0] opnd_addr = 24'h0;
    logic [7:0]  dst_bank = 8'h0;
    logic [7:0]  src_bank = 8'h0;
    logic [23:0] idx_addr;
    logic [23:0] mv_src_addr;
    logic [23:0] mv_dst_addr;
    logic [15:0] mac_mcand_ptr;
    logic [15:0] mac_mplier_ptr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_regbank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_byte(acc_byte), .idx_byte(idx_byte), .rd_sel(rd_sel),
        .rd_data(rd_data), .rd_full(rd_full), .opnd_addr(opnd_addr),
        .dst_bank(dst_bank), .src_bank(src_bank), .idx_addr(idx_addr),
        .mv_src_addr(mv_src_addr), .mv_dst_addr(mv_dst_addr),
        .mac_mcand_ptr(mac_mcand_ptr), .mac_mplier_ptr(mac_mplier_ptr)
    );

    task automatic cmp(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on a falling edge; the write lands at the following rising edge.
    task automatic put(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek_full(input logic [1:0] sel, output logic [15:0] v);
        rd_sel = sel;
        #1;
        v = rd_full;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int i = 0; i < 4; i++) begin
            peek_full(2'(i), v);
            cmp("R1 reset value", {8'h0, v}, 24'h0);
        end
    endtask

    task automatic t_wide_write;
        logic [15:0] v;
        acc_byte = 1'b0; idx_byte = 1'b0;
        put(2'd0, 16'h1234);
        put(2'd1, 16'h5678);
        put(2'd2, 16'h9ABC);
        put(2'd3, 16'hDEF0);
        peek_full(2'd0, v); cmp("R3 A word write", {8'h0, v}, 24'h001234);
        peek_full(2'd1, v); cmp("R2 B selected by code 1", {8'h0, v}, 24'h005678);
        peek_full(2'd2, v); cmp("R2 X selected by code 2", {8'h0, v}, 24'h009ABC);
        peek_full(2'd3, v); cmp("R3 Y word write", {8'h0, v}, 24'h00DEF0);
    endtask

    task automatic t_byte_write;
        logic [15:0] v;
        acc_byte = 1'b1; idx_byte = 1'b1;
        put(2'd0, 16'hABCD);
        put(2'd3, 16'h7711);
        peek_full(2'd0, v); cmp("R4 A byte write keeps high", {8'h0, v}, 24'h0012CD);
        peek_full(2'd3, v); cmp("R4 Y byte write keeps high", {8'h0, v}, 24'h00DE11);
        peek_full(2'd1, v); cmp("R2 B untouched", {8'h0, v}, 24'h005678);
        acc_byte = 1'b0; idx_byte = 1'b0;
    endtask

    task automatic t_flag_split;
        logic [15:0] v;
        // Accumulators narrow, index wide: X takes all 16 bits.
        acc_byte = 1'b1; idx_byte = 1'b0;
        put(2'd2, 16'h4455);
        put(2'd1, 16'hEE66);
        peek_full(2'd2, v); cmp("R5 acc flag ignored by X", {8'h0, v}, 24'h004455);
        peek_full(2'd1, v); cmp("R5 acc flag narrows B", {8'h0, v}, 24'h005666);
        // Index narrow, accumulators wide.
        acc_byte = 1'b0; idx_byte = 1'b1;
        put(2'd0, 16'hC3C3);
        put(2'd2, 16'h0099);
        peek_full(2'd0, v); cmp("R5 idx flag ignored by A", {8'h0, v}, 24'h00C3C3);
        peek_full(2'd2, v); cmp("R5 idx flag narrows X", {8'h0, v}, 24'h004499);
        idx_byte = 1'b0;
    endtask

    task automatic t_read_port;
        // A=C3C3, B=5666, X=4499, Y=DE11
        acc_byte = 1'b1; idx_byte = 1'b0;
        rd_sel = 2'd0; #1;
        cmp("R6 byte read zero-extends", {8'h0, rd_data}, 24'h0000C3);
        cmp("R6 full view in byte mode", {8'h0, rd_full}, 24'h00C3C3);
        rd_sel = 2'd3; #1;
        cmp("R6 word read of Y", {8'h0, rd_data}, 24'h00DE11);
        acc_byte = 1'b0; idx_byte = 1'b1;
        rd_sel = 2'd1; #1;
        cmp("R6 word read of B", {8'h0, rd_data}, 24'h005666);
        rd_sel = 2'd2; #1;
        cmp("R6 byte read of X", {8'h0, rd_data}, 24'h000099);
        idx_byte = 1'b0;
    endtask

    task automatic t_no_write;
        logic [15:0] v;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd1; wr_data = 16'hFFFF; acc_byte = 1'b1;
        repeat (2) @(negedge clk);
        peek_full(2'd1, v); cmp("R10 no write when wr_en low", {8'h0, v}, 24'h005666);
        acc_byte = 1'b0;
    endtask

    task automatic t_indexed;
        put(2'd2, 16'h12F0);
        idx_byte = 1'b0; opnd_addr = 24'h001000; #1;
        cmp("R7 indexed word", idx_addr, 24'h0022F0);
        idx_byte = 1'b1; #1;
        cmp("R7 indexed byte uses X low only", idx_addr, 24'h0010F0);
        idx_byte = 1'b0;
        put(2'd2, 16'h0020);
        opnd_addr = 24'hFFFFF0; #1;
        cmp("R7 indexed wraps at 24 bits", idx_addr, 24'h000010);
    endtask

    task automatic t_block_move;
        put(2'd2, 16'hA1B2);
        put(2'd3, 16'hC3D4);
        src_bank = 8'h7E; dst_bank = 8'h05; idx_byte = 1'b1; #1;
        cmp("R8 source pointer", mv_src_addr, 24'h7EA1B2);
        cmp("R8 destination pointer", mv_dst_addr, 24'h05C3D4);
        idx_byte = 1'b0;
    endtask

    task automatic t_mac;
        put(2'd2, 16'h0300);
        put(2'd3, 16'h0480);
        #1;
        cmp("R9 multiplicand pointer", {8'h0, mac_mcand_ptr}, 24'h000300);
        cmp("R9 multiplier pointer", {8'h0, mac_mplier_ptr}, 24'h000480);
    endtask

    task automatic t_reset_again;
        logic [15:0] v;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        peek_full(2'd3, v); cmp("R1 reset clears Y", {8'h0, v}, 24'h0);
        peek_full(2'd0, v); cmp("R1 reset clears A", {8'h0, v}, 24'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_wide_write();
        t_byte_write();
        t_flag_split();
        t_read_port();
        t_no_write();
        t_indexed();
        t_block_move();
        t_mac();
        t_reset_again();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule